// File: doc/BRIEF.md
# Steered Watchdog Timer

This block is a watchdog timer driven by a single byte-wide control register. The control byte holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. A restart loads a down-counter with the multiplier scaled by four to the power of the resolution code. The counter then steps once on each pulse of a 16 Hz tick enable, so the timeout is counted in sixteenths of a second.

When the count runs out, the block raises a sticky watchdog flag. It then takes one of two actions, chosen by the steering bit:
- It issues a one-clock system reset request, clears the control byte and clears a companion retained bit held in another register.
- It issues a one-clock interrupt pulse and changes nothing else.

Software keeps the watchdog alive in one of two ways. It can rewrite the control byte. It can also perform the servicing read of the flag register, which the surrounding decode signals with a single-cycle strobe. Both actions restart the count and clear the flag. Bus decode is reduced to write and read strobes. The reset request is an output only.

Top module: `wdg_steer`

## Requirements
- R1: After synchronous reset the control byte, the flag byte and the retained bit read zero, and neither the reset request nor the interrupt is asserted.
- R2: A control write stores the byte (bit 7 steering, bits 6:2 multiplier M, bits 1:0 resolution code C) and restarts the count. Expiry then happens on the tick numbered M × 4^C after the write, with ticks counted from the first tick after the write.
- R3: A control write clears the watchdog flag (bit 7 of the flag byte).
- R4: A servicing read strobe clears the watchdog flag and restarts the count from the control byte currently stored. A read that falls part-way through a count therefore postpones expiry by a full timeout.
- R5: At expiry bit 7 of the flag byte becomes 1. Bits 6:0 of the flag byte always read 0, and the flag rises only together with an expiry action.
- R6: If the steering bit is 1 at expiry, the reset request is high for exactly one clock. In that same clock the control byte reads 0x00 and the retained bit reads 0. Because the control byte is now zero, a later servicing read leaves the watchdog disabled.
- R7: If the steering bit is 0 at expiry, the interrupt is high for exactly one clock, and the control byte and the retained bit keep their values.
- R8: A multiplier of zero disables the watchdog, and no number of ticks produces an expiry.
- R9: After an expiry the count stays stopped, and further ticks produce no expiry until a restart.
- R10: A restart (control write or servicing read) in the same clock as the final tick takes priority. No expiry happens in that clock, and the full timeout starts again.
- R11: Only tick pulses advance the count. Clocks without a tick never produce an expiry.
- R12: A retained-bit write stores its data bit, except in a clock where a reset-steered expiry clears it. In that clock the clear wins.
- R13: The reset request and the interrupt are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16hz | input | 1 | One-clock enable pulse at 16 Hz |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| flag_rd | input | 1 | Servicing read strobe of the flag register |
| aux_we | input | 1 | Retained-bit write strobe |
| aux_wdata | input | 1 | Retained-bit write data |
| ctl_q | output | 8 | Stored control byte |
| flags_q | output | 8 | Flag byte, watchdog flag in bit 7 |
| aux_q | output | 1 | Retained bit |
| rst_req | output | 1 | One-clock system reset request |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The bench builds the block with the package defaults: a 5-bit multiplier, a 2-bit resolution code and an 11-bit counter. These values put the full range of timeouts within reach, from one tick up to 1984 ticks, and the vector table includes both ends. The tick enable fires on every clock while a timeout is being run, so even the longest count finishes in a few thousand cycles. This also makes the final-tick collision with a restart easy to place on an exact clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CTL_W  = 8;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    // largest shift is 2*(2^RES_W - 1)
    localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W  = MULT_W + MAX_SHIFT;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdg_ctl_t;

    // timeout length in ticks: mult * 4^res
    function automatic logic [CNT_W-1:0] wdg_ticks(input wdg_ctl_t c);
        logic [CNT_W-1:0] base;
        base = CNT_W'(c.mult);
        return base << {c.res, 1'b0};
    endfunction

endpackage

// File: rtl/wdg_ctl_reg.sv
module wdg_ctl_reg
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  wdg_ctl_t wr_data,
    input  logic     wipe,
    input  logic     aux_we,
    input  logic     aux_d,
    output wdg_ctl_t ctl_q,
    output logic     aux_q
);

    // a write restarts the count, so it never meets a wipe in one clock
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= wr_data;
        end else if (wipe) begin
            ctl_q <= '0;
        end
    end

    // the clear from a reset-steered expiry beats a software write
    always_ff @(posedge clk) begin
        if (rst) begin
            aux_q <= 1'b0;
        end else if (wipe) begin
            aux_q <= 1'b0;
        end else if (aux_we) begin
            aux_q <= aux_d;
        end
    end

endmodule

// File: rtl/wdg_count.sv
module wdg_count
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;
    logic             armed;

    assign expire = armed && tick && (cnt == CNT_W'(1)) && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cnt   <= load_val;
            armed <= (load_val != '0);
        end else if (expire) begin
            armed <= 1'b0;
        end else if (armed && tick) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/wdg_action.sv
module wdg_action (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic steer,
    input  logic restart,
    output logic wipe,
    output logic flag,
    output logic rst_req,
    output logic irq
);

    assign wipe = expire && steer;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            rst_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= expire && steer;
            irq     <= expire && !steer;
            if (expire) begin
                flag <= 1'b1;
            end else if (restart) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdg_steer.sv
module wdg_steer
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_16hz,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             flag_rd,
    input  logic             aux_we,
    input  logic             aux_wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic [CTL_W-1:0] flags_q,
    output logic             aux_q,
    output logic             rst_req,
    output logic             irq
);

    wdg_ctl_t         wdata_s;
    wdg_ctl_t         ctl_s;
    logic             restart;
    logic             expire;
    logic             wipe;
    logic             flag;
    logic [CNT_W-1:0] load_val;

    assign wdata_s  = wdg_ctl_t'(ctl_wdata);
    assign restart  = ctl_we || flag_rd;
    // a fresh write wins over a service read in the same clock
    assign load_val = ctl_we ? wdg_ticks(wdata_s) : wdg_ticks(ctl_s);

    wdg_ctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_we),
        .wr_data (wdata_s),
        .wipe    (wipe),
        .aux_we  (aux_we),
        .aux_d   (aux_wdata),
        .ctl_q   (ctl_s),
        .aux_q   (aux_q)
    );

    wdg_count u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (restart),
        .load_val (load_val),
        .tick     (tick_16hz),
        .expire   (expire)
    );

    wdg_action u_act (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .steer   (ctl_s.steer),
        .restart (restart),
        .wipe    (wipe),
        .flag    (flag),
        .rst_req (rst_req),
        .irq     (irq)
    );

    assign ctl_q   = CTL_W'(ctl_s);
    assign flags_q = {flag, {(CTL_W-1){1'b0}}};

endmodule

// File: rtl/wdg_steer_chk.sv
module wdg_steer_chk
    import wdg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick_16hz,
    input logic             ctl_we,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic             flag_rd,
    input logic             aux_we,
    input logic             aux_wdata,
    input logic [CTL_W-1:0] ctl_q,
    input logic [CTL_W-1:0] flags_q,
    input logic             aux_q,
    input logic             rst_req,
    input logic             irq
);

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_q == $past(ctl_wdata)) && !flags_q[CTL_W-1]); // R2

    AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> !flags_q[CTL_W-1]); // R3

    AST_SERVICE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        flag_rd |=> !flags_q[CTL_W-1]); // R4

    AST_FLAG_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        flags_q[CTL_W-2:0] == '0); // R5

    AST_FLAG_RISE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[CTL_W-1]) |-> (rst_req || irq)); // R5

    AST_RESET_WIPES: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (ctl_q == '0) && !aux_q && flags_q[CTL_W-1]); // R6

    AST_RESET_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req); // R6

    AST_IRQ_KEEPS_CTL: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctl_q == $past(ctl_q)) && flags_q[CTL_W-1]); // R7

    AST_IRQ_KEEPS_AUX: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(aux_we)) |-> (aux_q == $past(aux_q))); // R7

    AST_IRQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R7

    AST_NO_TICK_NO_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        !tick_16hz |=> !rst_req && !irq); // R11

    AST_AUX_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($past(aux_we) && !rst_req) |-> (aux_q == $past(aux_wdata))); // R12

    AST_ACTIONS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && irq)); // R13

endmodule

bind wdg_steer wdg_steer_chk u_chk (.*);

// File: tb/wdg_steer_tb.sv
module wdg_steer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16hz = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       flag_rd = 1'b0;
    logic       aux_we = 1'b0;
    logic       aux_wdata = 1'b0;
    logic [7:0] ctl_q;
    logic [7:0] flags_q;
    logic       aux_q;
    logic       rst_req;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdg_steer u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_16hz (tick_16hz),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .flag_rd   (flag_rd),
        .aux_we    (aux_we),
        .aux_wdata (aux_wdata),
        .ctl_q     (ctl_q),
        .flags_q   (flags_q),
        .aux_q     (aux_q),
        .rst_req   (rst_req),
        .irq       (irq)
    );

    // {control byte, expected timeout in ticks}, steering bit clear
    localparam logic [18:0] VEC [0:6] = '{
        {8'h04, 11'd1},
        {8'h05, 11'd4},
        {8'h7C, 11'd31},
        {8'h0A, 11'd32},
        {8'h12, 11'd64},
        {8'h0B, 11'd128},
        {8'h7F, 11'd1984}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one clock of inputs at the falling edge, return at the next falling edge
    task automatic cyc(input logic t, input logic we, input logic [7:0] wd,
                       input logic rd, input logic awe, input logic ad);
        tick_16hz = t; ctl_we = we; ctl_wdata = wd;
        flag_rd = rd; aux_we = awe; aux_wdata = ad;
        @(posedge clk);
        @(negedge clk);
        tick_16hz = 1'b0; ctl_we = 1'b0; ctl_wdata = 8'h00;
        flag_rd = 1'b0; aux_we = 1'b0; aux_wdata = 1'b0;
    endtask

    task automatic run_ticks(input int maxn, output int hit_at,
                             output logic hit_rst, output logic hit_irq);
        hit_at = 0; hit_rst = 1'b0; hit_irq = 1'b0;
        for (int i = 1; i <= maxn; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
            if (rst_req || irq) begin
                hit_at = i; hit_rst = rst_req; hit_irq = irq;
                break;
            end
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int   at;
        logic hr;
        logic hi;
        int   quiet;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(ctl_q == 8'h00, "R1 ctl", ctl_q, 0);
        chk(flags_q == 8'h00, "R1 flags", flags_q, 0);
        chk(aux_q == 1'b0, "R1 aux", aux_q, 0);
        chk(!rst_req && !irq, "R1 actions", {rst_req, irq}, 0);

        // table: timeout arithmetic with interrupt steering
        for (int v = 0; v < 7; v++) begin
            logic [7:0]  c;
            logic [10:0] n;
            c = VEC[v][18:11];
            n = VEC[v][10:0];
            cyc(1'b0, 1'b1, c, 1'b0, 1'b0, 1'b0);
            chk(ctl_q == c, "R2 stored byte", ctl_q, c);
            run_ticks(int'(n) + 4, at, hr, hi);
            chk(at == int'(n), "R2 timeout ticks", at, n);
            chk(hi && !hr, "R7 interrupt steering", {hr, hi}, 1);
            chk(ctl_q == c, "R7 ctl kept", ctl_q, c);
            chk(flags_q == 8'h80, "R5 flag set", flags_q, 8'h80);
        end

        // R7 one clock, R9 stopped after expiry
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        chk(!irq, "R7 one-clock interrupt", irq, 0);
        run_ticks(40, at, hr, hi);
        chk(at == 0, "R9 no repeat expiry", at, 0);

        // R3 write clears flag
        cyc(1'b0, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0);
        chk(flags_q == 8'h00, "R3 flag cleared by write", flags_q, 0);
        run_ticks(8, at, hr, hi);
        chk(at == 4, "R2 restart after write", at, 4);

        // R4 service read clears flag and restarts
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        chk(flags_q == 8'h00, "R4 flag cleared by read", flags_q, 0);
        run_ticks(8, at, hr, hi);
        chk(at == 4, "R4 restart from stored byte", at, 4);
        run_ticks(3, at, hr, hi);
        chk(at == 0, "R9 stopped", at, 0);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        run_ticks(3, at, hr, hi);
        chk(at == 0, "R4 partial count", at, 0);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        run_ticks(8, at, hr, hi);
        chk(at == 4, "R4 read mid-count postpones", at, 4);

        // R10 restart on the final tick wins
        cyc(1'b0, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0);
        run_ticks(3, at, hr, hi);
        cyc(1'b1, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0);
        chk(!rst_req && !irq, "R10 write on final tick", {rst_req, irq}, 0);
        run_ticks(8, at, hr, hi);
        chk(at == 4, "R10 full timeout again", at, 4);
        cyc(1'b0, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0);
        run_ticks(3, at, hr, hi);
        cyc(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        chk(!rst_req && !irq, "R10 read on final tick", {rst_req, irq}, 0);
        run_ticks(8, at, hr, hi);
        chk(at == 4, "R10 full timeout after read", at, 4);

        // R11 no ticks, no expiry
        cyc(1'b0, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0);
        quiet = 0;
        for (int i = 0; i < 30; i++) begin
            cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
            if (rst_req || irq) quiet++;
        end
        chk(quiet == 0, "R11 idle clocks", quiet, 0);
        run_ticks(3, at, hr, hi);
        chk(at == 1, "R11 tick then expiry", at, 1);

        // R8 zero multiplier
        cyc(1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0);
        run_ticks(300, at, hr, hi);
        chk(at == 0, "R8 mult zero res 3", at, 0);
        cyc(1'b0, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0);
        run_ticks(100, at, hr, hi);
        chk(at == 0, "R8 mult zero steer set", at, 0);

        // R12 retained bit write
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
        chk(aux_q == 1'b1, "R12 aux write", aux_q, 1);

        // R7 interrupt keeps retained bit
        cyc(1'b0, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0);
        run_ticks(3, at, hr, hi);
        chk(hi && aux_q, "R7 aux kept", {hi, aux_q}, 3);

        // R6 reset steering
        cyc(1'b0, 1'b1, 8'h85, 1'b0, 1'b0, 1'b0);
        run_ticks(8, at, hr, hi);
        chk(at == 4, "R6 timeout ticks", at, 4);
        chk(hr && !hi, "R6 reset request", {hr, hi}, 2);
        chk(ctl_q == 8'h00, "R6 ctl cleared", ctl_q, 0);
        chk(aux_q == 1'b0, "R6 aux cleared", aux_q, 0);
        chk(flags_q == 8'h80, "R5 flag on reset expiry", flags_q, 8'h80);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        chk(!rst_req, "R6 one-clock request", rst_req, 0);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        chk(flags_q == 8'h00, "R4 flag cleared", flags_q, 0);
        run_ticks(60, at, hr, hi);
        chk(at == 0, "R6 disabled after wipe", at, 0);

        // R12 clear wins over a write in the expiry clock
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 8'h84, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
        chk(rst_req && !aux_q, "R12 clear beats write", {rst_req, aux_q}, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule